// File: doc/BRIEF.md
# Linear CCD Line Readout Timing Generator

This block drives a linear CCD line sensor from a fast system clock. For each line it produces a transfer-gate pulse framed by guard intervals, then a burst of two complementary shift clocks in which every period of `phi1` moves one pixel to the sensor output. For each of those periods it also reports a pixel number, a one-cycle strobe at mid-period and a region code. A downstream sampler uses these to decide which samples are dark reference, which are discarded and which are image data.

The shift rate is set at run time as a half-period count in system-clock cycles. That count is forced into the range the sensor accepts and is captured once per line. A line starts on a request. If a request arrives while a line is still running, it is held and the next line follows straight after the last shift period. The transfer-gate width and the guard length are parameters in system-clock cycles. Elaboration stops if either one is shorter than the sensor's minimum at the stated clock frequency.

Top module: `ccd_line_timer`

## Requirements
- R1: After reset `phi_tg`=0, `phi1`=1, `phi2`=0, `pix_stb`=0, `region`=0 and `pix_idx`=0.
- R2: When `en` is high and `line_req` is high at a rising edge while the block is idle, a line begins. `phi1` stays high for GUARD_W cycles, then `phi_tg` is high for TG_W cycles, then `phi1` stays high for GUARD_W more cycles before its first fall. Elaboration fails if TG_W is under ceil(650 ns) or GUARD_W is under ceil(100 ns) of system clock.
- R3: `phi2` is always the inverse of `phi1`.
- R4: Each line issues exactly N_LINE = N_UNST+N_OB+N_INV+N_VALID+N_TAIL+N_PAD shift periods (2124 by default). Each period is H cycles with `phi1` low followed by H cycles with `phi1` high. `phi1` stays high after the last period.
- R5: H equals `div_half` clamped to [ceil(f/4 MHz), floor(f/0.4 MHz)], which is 13..125 at 50 MHz. It is sampled when the line starts, and a change to `div_half` during a line has no effect on that line.
- R6: `pix_stb` is high for exactly one cycle per shift period, in the first cycle of the high half of `phi1`. `pix_idx` gives the 0-based period number during shifting and is 0 at all other times.
- R7: `region` is 0 outside shifting. During shifting it depends on the period number p: p<N_UNST gives 1 (unstable); the next N_OB periods give 2 (black reference); the next N_INV give 3 (invalid); the next N_VALID give 4 (valid); all remaining periods give 3.
- R8: A period in the unstable run never carries code 2. Code 2 appears only after at least N_UNST strobes have been issued since the transfer-gate pulse.
- R9: A `line_req` pulse during a line is held. With `en` high, the next line's first guard cycle follows immediately after the last high half. Without a held request, the block returns to idle and issues no further pulse.
- R10: While idle with `en` low, `line_req` is ignored and not remembered. Dropping `en` during a line does not cut that line short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Allows lines to start |
| div_half | input | DIV_W | Requested shift half-period in clock cycles |
| line_req | input | 1 | Line start request |
| phi_tg | output | 1 | Transfer-gate pulse |
| phi1 | output | 1 | Shift clock 1 |
| phi2 | output | 1 | Shift clock 2, inverse of phi1 |
| pix_stb | output | 1 | One-cycle strobe at mid shift period |
| pix_idx | output | IDX_W | Current shift period number |
| region | output | 3 | Region code of current period |

## Verification
Every output comes straight from a register. A request sampled at edge k therefore shows its first guard cycle after edge k. The pulse rises GUARD_W cycles later, and the first `phi1` fall comes 2·GUARD_W+TG_W cycles after the guard began. The strobe for period p falls on cycle 2·GUARD_W+TG_W+2Hp+H of the line. The bench pulses `line_req` on a falling edge and then walks the line one falling edge at a time. At each step it compares all six outputs with a timeline computed from these offsets, so every result is sampled half a cycle after the edge that produced it. Back-to-back lines are checked by starting the next timeline on the cycle that follows the last high half.

// File: rtl/ccd_tmg_pkg.sv
package ccd_tmg_pkg;

    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_UNST  = 3'd1,
        RG_BLACK = 3'd2,
        RG_INVAL = 3'd3,
        RG_VALID = 3'd4
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_GATE  = 3'd2,
        ST_POST  = 3'd3,
        ST_SHIFT = 3'd4
    } seq_e;

endpackage

// File: rtl/ccd_rate_clamp.sv
module ccd_rate_clamp #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 13,
    parameter int MAX_HALF = 125
) (
    input  logic [DIV_W-1:0] div_in,
    output logic [DIV_W-1:0] half_out
);
    localparam logic [DIV_W-1:0] LO = DIV_W'(MIN_HALF);
    localparam logic [DIV_W-1:0] HI = DIV_W'(MAX_HALF);

    if (MAX_HALF >= (1 << DIV_W)) begin : g_bad_width
        $error("DIV_W too narrow for slowest shift rate");
    end

    always_comb begin
        if (div_in < LO)      half_out = LO;
        else if (div_in > HI) half_out = HI;
        else                  half_out = div_in;
    end
endmodule

// File: rtl/ccd_region_map.sv
module ccd_region_map
    import ccd_tmg_pkg::*;
#(
    parameter int IDX_W   = 12,
    parameter int N_UNST  = 12,
    parameter int N_OB    = 18,
    parameter int N_INV   = 2,
    parameter int N_VALID = 2088
) (
    input  logic             active,
    input  logic [IDX_W-1:0] idx,
    output region_e          code
);
    localparam int B_UNST  = N_UNST;
    localparam int B_BLACK = B_UNST + N_OB;
    localparam int B_INV   = B_BLACK + N_INV;
    localparam int B_VALID = B_INV + N_VALID;

    int pos;

    always_comb begin
        pos = 32'(idx);
        if (!active)             code = RG_NONE;
        else if (pos < B_UNST)   code = RG_UNST;
        else if (pos < B_BLACK)  code = RG_BLACK;
        else if (pos < B_INV)    code = RG_INVAL;
        else if (pos < B_VALID)  code = RG_VALID;
        else                     code = RG_INVAL;
    end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
    import ccd_tmg_pkg::*;
#(
    parameter int CLK_KHZ = 50000,
    parameter int DIV_W   = 8,
    parameter int TG_W    = 50,
    parameter int GUARD_W = 5,
    parameter int N_UNST  = 12,
    parameter int N_OB    = 18,
    parameter int N_INV   = 2,
    parameter int N_VALID = 2088,
    parameter int N_TAIL  = 2,
    parameter int N_PAD   = 2,
    localparam int N_LINE = N_UNST + N_OB + N_INV + N_VALID + N_TAIL + N_PAD,
    localparam int IDX_W  = $clog2(N_LINE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_half,
    input  logic             line_req,
    output logic             phi_tg,
    output logic             phi1,
    output logic             phi2,
    output logic             pix_stb,
    output logic [IDX_W-1:0] pix_idx,
    output logic [2:0]       region
);
    // sensor limits converted to clock cycles (rounded toward safety)
    localparam int MIN_HALF  = (CLK_KHZ + 3999) / 4000;
    localparam int MAX_HALF  = CLK_KHZ / 400;
    localparam int TG_MIN    = (CLK_KHZ * 650 + 999999) / 1000000;
    localparam int GUARD_MIN = (CLK_KHZ * 100 + 999999) / 1000000;
    localparam int CNT_TOP   = (TG_W > GUARD_W)
                             ? ((TG_W > MAX_HALF) ? TG_W : MAX_HALF)
                             : ((GUARD_W > MAX_HALF) ? GUARD_W : MAX_HALF);
    localparam int CNT_W     = $clog2(CNT_TOP + 1);

    if (TG_W < TG_MIN) begin : g_gate_short
        $error("TG_W below minimum transfer-gate width");
    end
    if (GUARD_W < GUARD_MIN) begin : g_guard_short
        $error("GUARD_W below minimum guard interval");
    end

    typedef struct packed {
        seq_e             st;
        logic [CNT_W-1:0] cnt;
        logic             hi_half;
        logic [IDX_W-1:0] pix;
        logic [DIV_W-1:0] half;
        logic             pend;
        logic             tg;
        logic             p1;
        logic             p2;
        logic             stb;
    } regs_t;

    regs_t q, d;

    logic [DIV_W-1:0] half_c;
    logic             req_any;
    logic             last_cyc;
    region_e          code_c;

    ccd_rate_clamp #(
        .DIV_W   (DIV_W),
        .MIN_HALF(MIN_HALF),
        .MAX_HALF(MAX_HALF)
    ) u_clamp (
        .div_in  (div_half),
        .half_out(half_c)
    );

    always_comb begin
        d        = q;
        req_any  = q.pend | line_req;
        last_cyc = (q.cnt == CNT_W'(q.half - 1'b1));

        if (q.st != ST_IDLE && line_req) d.pend = 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (en && req_any) begin
                    d.st   = ST_PRE;
                    d.cnt  = '0;
                    d.half = half_c;
                    d.pend = 1'b0;
                end
            end
            ST_PRE: begin
                if (q.cnt == CNT_W'(GUARD_W - 1)) begin
                    d.st  = ST_GATE;
                    d.cnt = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_GATE: begin
                if (q.cnt == CNT_W'(TG_W - 1)) begin
                    d.st  = ST_POST;
                    d.cnt = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_POST: begin
                if (q.cnt == CNT_W'(GUARD_W - 1)) begin
                    d.st      = ST_SHIFT;
                    d.cnt     = '0;
                    d.hi_half = 1'b0;
                    d.pix     = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_SHIFT: begin
                if (!last_cyc) begin
                    d.cnt = q.cnt + 1'b1;
                end else begin
                    d.cnt = '0;
                    if (!q.hi_half) begin
                        d.hi_half = 1'b1;
                    end else if (q.pix == IDX_W'(N_LINE - 1)) begin
                        d.pix     = '0;
                        d.hi_half = 1'b0;
                        if (en && req_any) begin
                            d.st   = ST_PRE;
                            d.half = half_c;
                            d.pend = 1'b0;
                        end else begin
                            d.st   = ST_IDLE;
                            d.pend = req_any;
                        end
                    end else begin
                        d.hi_half = 1'b0;
                        d.pix     = q.pix + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        d.tg  = (d.st == ST_GATE);
        d.p1  = (d.st != ST_SHIFT) || d.hi_half;
        d.p2  = (d.st == ST_SHIFT) && !d.hi_half;
        d.stb = (d.st == ST_SHIFT) && d.hi_half && (d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.half    <= DIV_W'(MIN_HALF);
            q.p1      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    ccd_region_map #(
        .IDX_W  (IDX_W),
        .N_UNST (N_UNST),
        .N_OB   (N_OB),
        .N_INV  (N_INV),
        .N_VALID(N_VALID)
    ) u_map (
        .active(q.st == ST_SHIFT),
        .idx   (q.pix),
        .code  (code_c)
    );

    assign phi_tg  = q.tg;
    assign phi1    = q.p1;
    assign phi2    = q.p2;
    assign pix_stb = q.stb;
    assign pix_idx = q.pix;
    assign region  = code_c;
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
    parameter int TG_W    = 50,
    parameter int GUARD_W = 5,
    parameter int N_UNST  = 12,
    parameter int IDX_W   = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phi_tg,
    input logic             phi1,
    input logic             phi2,
    input logic             pix_stb,
    input logic [IDX_W-1:0] pix_idx,
    input logic [2:0]       region
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] pre_run, gate_run, post_run, stb_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_run  <= '0;
            gate_run <= '0;
            post_run <= SAT;
            stb_run  <= '0;
        end else begin
            if (!phi1)                           pre_run <= '0;
            else if (!phi_tg && pre_run != SAT)  pre_run <= pre_run + 1'b1;

            gate_run <= phi_tg ? gate_run + 1'b1 : '0;

            if (phi_tg)                          post_run <= '0;
            else if (!phi1)                      post_run <= SAT;
            else if (post_run != SAT)            post_run <= post_run + 1'b1;

            if (phi_tg)                          stb_run <= '0;
            else if (pix_stb && stb_run != SAT)  stb_run <= stb_run + 1'b1;
        end
    end

    assert_clocks_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phi2 != phi1);

    assert_gate_phi1_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phi_tg |-> phi1);

    assert_guard_before_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi_tg) |-> (pre_run >= 16'(GUARD_W)));

    assert_gate_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phi_tg) |-> (gate_run == 16'(TG_W)));

    assert_guard_after_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phi1) |-> (post_run >= 16'(GUARD_W)));

    assert_strobe_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |-> $rose(phi1));

    assert_rise_has_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi1) |-> pix_stb);

    assert_no_code_in_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phi_tg |-> (region == 3'd0));

    assert_black_after_unstable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (region == 3'd2) |-> (stb_run >= 16'(N_UNST)));
endmodule

bind ccd_line_timer ccd_line_timer_chk #(
    .TG_W   (TG_W),
    .GUARD_W(GUARD_W),
    .N_UNST (N_UNST),
    .IDX_W  (IDX_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .phi_tg (phi_tg),
    .phi1   (phi1),
    .phi2   (phi2),
    .pix_stb(pix_stb),
    .pix_idx(pix_idx),
    .region (region)
);

// File: tb/ccd_line_timer_tb_top.sv
module ccd_line_timer_tb_top;
    localparam int CLK_PERIOD = 20;
    localparam int GW   = 5;
    localparam int TGW  = 34;
    localparam int NU   = 3;
    localparam int NO   = 4;
    localparam int NI   = 2;
    localparam int NV   = 6;
    localparam int NT   = 2;
    localparam int NP   = 1;
    localparam int NL   = NU + NO + NI + NV + NT + NP;
    localparam int IW   = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [7:0]    div_half = 8'd13;
    logic          line_req = 1'b0;
    logic          phi_tg, phi1, phi2, pix_stb;
    logic [IW-1:0] pix_idx;
    logic [2:0]    region;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    ccd_line_timer #(
        .CLK_KHZ(50000), .DIV_W(8), .TG_W(TGW), .GUARD_W(GW),
        .N_UNST(NU), .N_OB(NO), .N_INV(NI), .N_VALID(NV), .N_TAIL(NT), .N_PAD(NP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .div_half(div_half), .line_req(line_req),
        .phi_tg(phi_tg), .phi1(phi1), .phi2(phi2), .pix_stb(pix_stb),
        .pix_idx(pix_idx), .region(region)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int p);
        if (p < NU)                return 1;
        if (p < NU + NO)           return 2;
        if (p < NU + NO + NI)      return 3;
        if (p < NU + NO + NI + NV) return 4;
        return 3;
    endfunction

    // walk one line from its first guard cycle; sampled on falling edges
    task automatic walk_line(input int h, input int req_at, input int div_at, input int en_at);
        int total;
        int bad_seq, bad_cpl, bad_stb, bad_idx, bad_reg, bad_r8;
        int a_seq, e_seq, a_reg, e_reg, a_idx, e_idx;
        int n_stb;
        total   = 2 * GW + TGW + NL * 2 * h;
        bad_seq = 0; bad_cpl = 0; bad_stb = 0; bad_idx = 0; bad_reg = 0; bad_r8 = 0;
        a_seq = 0; e_seq = 0; a_reg = 0; e_reg = 0; a_idx = 0; e_idx = 0;
        n_stb = 0;
        for (int s = 0; s < total; s++) begin
            int x_tg, x_p1, x_stb, x_idx, x_reg;
            x_tg = 0; x_p1 = 1; x_stb = 0; x_idx = 0; x_reg = 0;
            if (s >= GW && s < GW + TGW) x_tg = 1;
            if (s >= 2 * GW + TGW) begin
                int k, p, r;
                k = s - (2 * GW + TGW);
                p = k / (2 * h);
                r = k % (2 * h);
                x_p1  = (r >= h) ? 1 : 0;
                x_stb = (r == h) ? 1 : 0;
                x_idx = p;
                x_reg = exp_code(p);
                if (p < NU && region == 3'd2) bad_r8++;
            end
            if (int'(phi_tg) != x_tg || int'(phi1) != x_p1) begin
                if (bad_seq == 0) begin a_seq = s; e_seq = int'(phi_tg) * 2 + int'(phi1); end
                bad_seq++;
            end
            if (phi2 == phi1) bad_cpl++;
            if (int'(pix_stb) != x_stb) bad_stb++;
            n_stb += int'(pix_stb);
            if (int'(pix_idx) != x_idx) begin
                if (bad_idx == 0) begin a_idx = int'(pix_idx); e_idx = x_idx; end
                bad_idx++;
            end
            if (int'(region) != x_reg) begin
                if (bad_reg == 0) begin a_reg = int'(region); e_reg = x_reg; end
                bad_reg++;
            end
            if (s == req_at)     line_req = 1'b1;
            if (s == req_at + 1) line_req = 1'b0;
            if (s == div_at)     div_half = 8'd200;
            if (s == en_at)      en = 1'b0;
            @(negedge clk);
        end
        check(bad_seq == 0, "R2/R4 gate and phi1 timeline (first bad step)", a_seq, e_seq);
        check(bad_cpl == 0, "R3 phi2 inverse of phi1 (bad cycles)", bad_cpl, 0);
        check(bad_stb == 0, "R6 strobe placement (bad cycles)", bad_stb, 0);
        check(n_stb == NL, "R4 shift periods per line", n_stb, NL);
        check(bad_idx == 0, "R6 pixel index", a_idx, e_idx);
        check(bad_reg == 0, "R7 region code", a_reg, e_reg);
        check(bad_r8 == 0, "R8 unstable never black", bad_r8, 0);
    endtask

    task automatic idle_gap(input int n, input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (phi_tg || !phi1 || pix_stb || region != 3'd0) bad++;
            @(negedge clk);
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic pulse_req();
        line_req = 1'b1;
        @(negedge clk);
        line_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(phi_tg == 1'b0, "R1 phi_tg reset", int'(phi_tg), 0);
        check(phi1 == 1'b1, "R1 phi1 reset", int'(phi1), 1);
        check(phi2 == 1'b0, "R1 phi2 reset", int'(phi2), 0);
        check(pix_stb == 1'b0, "R1 pix_stb reset", int'(pix_stb), 0);
        check(region == 3'd0, "R1 region reset", int'(region), 0);
        check(pix_idx == '0, "R1 pix_idx reset", int'(pix_idx), 0);
    endtask

    task automatic t_basic();
        en = 1'b1; div_half = 8'd13;
        pulse_req();
        walk_line(13, -5, -5, -5);
        idle_gap(GW + TGW + 4, "R9 no extra line without request");
    endtask

    task automatic t_clamp_low();
        div_half = 8'd3;
        pulse_req();
        walk_line(13, -5, -5, -5);
        idle_gap(4, "R5 idle after clamped-low line");
    endtask

    task automatic t_clamp_high();
        div_half = 8'd200;
        pulse_req();
        walk_line(125, -5, -5, -5);
        idle_gap(4, "R5 idle after clamped-high line");
    endtask

    task automatic t_div_change();
        div_half = 8'd20;
        pulse_req();
        walk_line(20, -5, 2 * GW + TGW + 50, -5);
        idle_gap(4, "R5 idle after mid-line divider change");
    endtask

    task automatic t_pending();
        div_half = 8'd14;
        pulse_req();
        walk_line(14, 2 * GW + TGW + 30, -5, -5);
        walk_line(14, -5, -5, -5);
        idle_gap(GW + TGW + 4, "R9 single held request gives one extra line");
    endtask

    task automatic t_enable();
        en = 1'b0; div_half = 8'd13;
        pulse_req();
        idle_gap(200, "R10 request ignored while disabled");
        en = 1'b1;
        idle_gap(100, "R10 ignored request not remembered");
        pulse_req();
        walk_line(13, -5, -5, 2 * GW + TGW + 40);
        idle_gap(GW + TGW + 4, "R10 line completes after enable drop");
        en = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_clamp_low();
        t_clamp_high();
        t_div_change();
        t_pending();
        t_enable();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("[TB] FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule